// File: doc/BRIEF.md
# Multiple-Header Uncorrectable Error Log

This block holds the logging state that goes with uncorrectable error status: a pointer to the status bit of the error currently on record, a copy of that error's transaction header, and an optional copy of its end-to-end prefix words. Each incoming error request carries one status bit and its captured words. When no earlier error is still pending, the request is written straight into the log registers. When multiple-header recording is switched on and the status bit under the pointer is still set, the request waits in a small queue instead. If the queue is full, the request is dropped and an overflow pulse is raised.

The surrounding status register block holds the uncorrectable status. It presents that status to this block on every cycle, and it reports each software write as the status value that results from the write. When software clears the bit under the pointer, the oldest queued error moves into the log. At the same time the block asks the status register to set again the bits of every error that was waiting. Software therefore cannot clear the status of an error whose header it has not yet seen. If recording is switched off while the bit under the pointer stays set, the queue is emptied.

Top module: `mhr_err_log`

## Requirements
- R1: One cycle after an error request is logged, `fep` holds the bit index (0 to 31) of the single set bit of `req_status`.
- R2: When a logged request has `req_hdr_vld` set, each 32-bit word i of `hdr_log` (bits 32i+31:32i) is word i of `req_hdr` with its four bytes reversed. When that flag is clear, `hdr_log` becomes all zeros.
- R3: `pfx_log_present` is set, and `pfx_log` holds the byte-reversed prefix words (same word layout as R2), only when the logged request has `req_pfx_pres` set and `pfx_support_en` is high. In every other case the flag and `pfx_log` become zero.
- R4: A request is queued and leaves the log unchanged when recording is enabled and `stat_cur[fep]` is 1. If the queue already holds QDEPTH entries, the request is dropped and `ovf_pulse` is high for exactly the following cycle.
- R5: A status write with `stat_new[fep]` equal to 0 clears `fep`, `pfx_log_present`, `hdr_log` and `pfx_log` when recording is disabled or the queue is empty.
- R6: A status write with `stat_new[fep]` equal to 0, made while recording is enabled and the queue is not empty, loads the oldest queued error into the log under the rules of R1 to R3. On the next cycle it also raises `reassert_valid` with `reassert_mask` equal to the OR of the status bits of all entries queued before the write, the loaded entry included.
- R7: A status write that leaves `stat_new[fep]` at 1 while recording is enabled and the queue is not empty raises `reassert_valid` on the next cycle, with the OR of the queued status bits, and leaves the log and the queue unchanged.
- R8: A status write that leaves `stat_new[fep]` at 1 while recording is disabled empties the queue. A later clear of that bit then behaves as in R5, even if recording has been re-enabled.
- R9: `mhr_capable` is 1 exactly when QDEPTH is greater than 0, and `mhr_enabled` is `mhr_enable_req` gated by that capability.
- R10: After reset `fep`, `pfx_log_present`, `hdr_log`, `pfx_log`, `ovf_pulse` and `reassert_valid` are all zero.
- R11: When `stat_wr` and `req_valid` are both high in one cycle, the write is handled and the request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mhr_enable_req | input | 1 | Software enable for multiple-header recording |
| pfx_support_en | input | 1 | End-to-end prefix support enabled |
| req_valid | input | 1 | Error log request strobe |
| req_status | input | 32 | One-hot status bit of the error |
| req_hdr | input | 128 | Four captured header words, word i at bits 32i+31:32i |
| req_pfx | input | 128 | Four captured prefix words, same layout |
| req_hdr_vld | input | 1 | Header words are valid |
| req_pfx_pres | input | 1 | Prefix words are present |
| stat_cur | input | 32 | Current uncorrectable status register value |
| stat_wr | input | 1 | Software wrote the status register this cycle |
| stat_new | input | 32 | Status value resulting from that write |
| mhr_capable | output | 1 | Multiple-header recording is available |
| mhr_enabled | output | 1 | Multiple-header recording is in effect |
| fep | output | 5 | First-error pointer |
| pfx_log_present | output | 1 | Prefix log holds valid words |
| hdr_log | output | 128 | Header log registers |
| pfx_log | output | 128 | Prefix log registers |
| ovf_pulse | output | 1 | A request was dropped because the queue was full |
| reassert_valid | output | 1 | Request to set status bits again |
| reassert_mask | output | 32 | Status bits to set again |

## Verification
The assertions take for granted that every request has exactly one status bit set. They also assume that the status register block ORs `reassert_mask` back into the status, so every queued error's bit stays visible in `stat_cur`. The stimulus acts as that register block. It sets the status bit of each request the cycle after the request, applies each write as a clear of chosen bits, and folds in every re-assert mask it receives. It only ever picks status bits 1 to 31, so bit 0, which the pointer shows after a clear, is never set.

// File: rtl/mhr_log_pkg.sv
package mhr_log_pkg;

    localparam int STAT_W    = 32;
    localparam int IDX_W     = $clog2(STAT_W);
    localparam int WORD_W    = 32;
    localparam int LOG_WORDS = 4;
    localparam int LOG_W     = WORD_W * LOG_WORDS;
    localparam int BYTES_PW  = WORD_W / 8;

    // one captured error as it travels from request port to log
    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [LOG_W-1:0]  hdr;
        logic [LOG_W-1:0]  pfx;
        logic              hdr_vld;
        logic              pfx_pres;
    } err_rec_t;

    // index of the set bit of a one-hot status vector
    function automatic logic [IDX_W-1:0] bit_index(input logic [STAT_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < STAT_W; i++) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // reverse the byte order inside every word of a log block
    function automatic logic [LOG_W-1:0] swap_words(input logic [LOG_W-1:0] d);
        logic [LOG_W-1:0] r;
        for (int w = 0; w < LOG_WORDS; w++) begin
            for (int b = 0; b < BYTES_PW; b++) begin
                r[w*WORD_W + b*8 +: 8] = d[w*WORD_W + (BYTES_PW-1-b)*8 +: 8];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mhr_queue.sv
module mhr_queue
    import mhr_log_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  err_rec_t          push_rec,
    input  logic              pop,
    input  logic              flush,
    output err_rec_t          head_rec,
    output logic              empty,
    output logic              full,
    output logic [STAT_W-1:0] pend_mask
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    err_rec_t          slots [DEPTH];
    logic [PTR_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;
    logic [DEPTH-1:0]  live;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == FULL_CNT);
    assign head_rec = slots[head];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= wrap_inc(tail);
            if (pop)  head <= wrap_inc(head);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) slots[tail] <= push_rec;
    end

    // a slot is occupied when its distance from the head is below the count
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign live[g] = CNT_W'((g + DEPTH - int'(head)) % DEPTH) < count;
    end

    always_comb begin
        pend_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i]) pend_mask = pend_mask | slots[i].status;
        end
    end

    AST_Q_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop)); // R4
    AST_Q_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R6
    AST_Q_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT); // R4
    AST_Q_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty); // R8

endmodule

// File: rtl/mhr_log_regs.sv
module mhr_log_regs
    import mhr_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear,
    input  err_rec_t         rec,
    input  logic             pfx_support_en,
    output logic [IDX_W-1:0] fep,
    output logic             pfx_flag,
    output logic [LOG_W-1:0] hdr_log,
    output logic [LOG_W-1:0] pfx_log
);

    logic take_pfx;

    assign take_pfx = rec.pfx_pres && pfx_support_en;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fep      <= '0;
            pfx_flag <= 1'b0;
            hdr_log  <= '0;
            pfx_log  <= '0;
        end else if (load) begin
            fep      <= bit_index(rec.status);
            hdr_log  <= rec.hdr_vld ? swap_words(rec.hdr) : '0;
            pfx_flag <= take_pfx;
            pfx_log  <= take_pfx ? swap_words(rec.pfx) : '0;
        end
    end

    AST_LOAD_CLEAR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && clear)); // R5
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (fep == '0 && hdr_log == '0 && !pfx_flag)); // R5
    AST_PFX_FLAG_GATES: assert property (@(posedge clk) disable iff (rst)
        !pfx_flag |-> (pfx_log == '0)); // R3
    AST_HDR_ZERO_NOVLD: assert property (@(posedge clk) disable iff (rst)
        (load && !rec.hdr_vld) |=> (hdr_log == '0)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !clear) |=> ($stable(fep) && $stable(hdr_log))); // R4

endmodule

// File: rtl/mhr_err_log.sv
module mhr_err_log
    import mhr_log_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mhr_enable_req,
    input  logic          pfx_support_en,
    input  logic          req_valid,
    input  logic [31:0]   req_status,
    input  logic [127:0]  req_hdr,
    input  logic [127:0]  req_pfx,
    input  logic          req_hdr_vld,
    input  logic          req_pfx_pres,
    input  logic [31:0]   stat_cur,
    input  logic          stat_wr,
    input  logic [31:0]   stat_new,
    output logic          mhr_capable,
    output logic          mhr_enabled,
    output logic [4:0]    fep,
    output logic          pfx_log_present,
    output logic [127:0]  hdr_log,
    output logic [127:0]  pfx_log,
    output logic          ovf_pulse,
    output logic          reassert_valid,
    output logic [31:0]   reassert_mask
);

    localparam bit CAPABLE = (QDEPTH > 0);

    err_rec_t          req_rec, head_rec, load_rec;
    logic              q_empty, q_full;
    logic [STAT_W-1:0] q_pend;
    logic              fep_live_now, fep_live_after;
    logic              wr_cleared, take_req, queue_it;
    logic              q_push, q_pop, q_flush;
    logic              log_load, log_clear, do_reassert;

    assign mhr_capable = CAPABLE;
    assign mhr_enabled = mhr_enable_req && CAPABLE;

    assign req_rec = '{status:   req_status,
                       hdr:      req_hdr,
                       pfx:      req_pfx,
                       hdr_vld:  req_hdr_vld,
                       pfx_pres: req_pfx_pres};

    // status bit under the pointer, seen before and after a software write
    assign fep_live_now   = stat_cur[fep];
    assign fep_live_after = stat_new[fep];

    // a software write wins over a request in the same cycle
    assign wr_cleared  = stat_wr && !fep_live_after;
    assign take_req    = req_valid && !stat_wr;
    assign queue_it    = take_req && mhr_enabled && fep_live_now;

    assign q_push      = queue_it && !q_full;
    assign q_pop       = wr_cleared && mhr_enabled && !q_empty;
    assign q_flush     = stat_wr && fep_live_after && !mhr_enabled;
    assign do_reassert = stat_wr && mhr_enabled && !q_empty;

    assign log_load    = (take_req && !queue_it) || q_pop;
    assign log_clear   = wr_cleared && !q_pop;
    assign load_rec    = q_pop ? head_rec : req_rec;

    if (CAPABLE) begin : g_queue
        mhr_queue #(.DEPTH(QDEPTH)) u_queue (
            .clk       (clk),
            .rst       (rst),
            .push      (q_push),
            .push_rec  (req_rec),
            .pop       (q_pop),
            .flush     (q_flush),
            .head_rec  (head_rec),
            .empty     (q_empty),
            .full      (q_full),
            .pend_mask (q_pend)
        );
    end else begin : g_noqueue
        assign head_rec = '0;
        assign q_empty  = 1'b1;
        assign q_full   = 1'b1;
        assign q_pend   = '0;
    end

    mhr_log_regs u_log (
        .clk            (clk),
        .rst            (rst),
        .load           (log_load),
        .clear          (log_clear),
        .rec            (load_rec),
        .pfx_support_en (pfx_support_en),
        .fep            (fep),
        .pfx_flag       (pfx_log_present),
        .hdr_log        (hdr_log),
        .pfx_log        (pfx_log)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_pulse      <= 1'b0;
            reassert_valid <= 1'b0;
            reassert_mask  <= '0;
        end else begin
            ovf_pulse      <= queue_it && q_full;
            reassert_valid <= do_reassert;
            reassert_mask  <= do_reassert ? q_pend : '0;
        end
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones(req_status) == 1)); // R1
    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> $past(q_full && req_valid)); // R4
    AST_REASSERT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        reassert_valid |-> (reassert_mask != '0)); // R6
    AST_NO_QUEUE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !mhr_enabled |-> !q_push); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && req_valid && fep_live_after) |=> $stable(fep)); // R11

endmodule

// File: tb/mhr_err_log_test.sv
module mhr_err_log_test;

    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mhr_enable_req = 1'b0, pfx_support_en = 1'b0;
    logic         req_valid = 1'b0, req_hdr_vld = 1'b0, req_pfx_pres = 1'b0;
    logic [31:0]  req_status = '0;
    logic [127:0] req_hdr = '0, req_pfx = '0;
    logic [31:0]  stat_cur = '0, stat_new = '0;
    logic         stat_wr = 1'b0;
    logic         mhr_capable, mhr_enabled, pfx_log_present, ovf_pulse, reassert_valid;
    logic [4:0]   fep;
    logic [127:0] hdr_log, pfx_log;
    logic [31:0]  reassert_mask;

    always #4 clk = ~clk;   // 125 MHz

    mhr_err_log #(.QDEPTH(DEPTH)) uut (.*);

    int n_checks = 0, n_errors = 0;
    bit cmp_on = 1'b0;
    logic [31:0]  stat_reg = '0;
    logic [127:0] hdr_pat = '0, pfx_pat = '0;

    // ---------------- behavioural reference ----------------
    typedef struct {
        logic [31:0]  st;
        logic [127:0] h, p;
        bit           hv, pp;
    } ent_t;

    ent_t         q[$];
    logic [4:0]   m_fep;
    logic [127:0] m_hdr, m_pfx;
    bit           m_pflag, m_ovf, m_rav;
    logic [31:0]  m_ram;

    function automatic logic [127:0] be(input logic [127:0] d);
        logic [127:0] r;
        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 4; b++)
                r[w*32 + b*8 +: 8] = d[w*32 + (3-b)*8 +: 8];
        return r;
    endfunction

    task automatic m_load(input ent_t e);
        for (int i = 0; i < 32; i++) if (e.st[i]) m_fep = 5'(i);
        m_hdr   = e.hv ? be(e.h) : '0;
        m_pflag = e.pp && pfx_support_en;
        m_pfx   = m_pflag ? be(e.p) : '0;
    endtask

    always @(posedge clk) begin
        ent_t e;
        logic [31:0] orm;
        if (rst) begin
            q.delete();
            m_fep = '0; m_hdr = '0; m_pfx = '0; m_pflag = 0;
            m_ovf = 0; m_rav = 0; m_ram = '0;
        end else begin
            m_ovf = 0; m_rav = 0; m_ram = '0;
            orm = '0;
            foreach (q[i]) orm |= q[i].st;
            if (stat_wr) begin
                if (!stat_new[m_fep]) begin
                    if (!mhr_enable_req || q.size() == 0) begin
                        m_fep = '0; m_hdr = '0; m_pfx = '0; m_pflag = 0;
                    end else begin
                        m_rav = 1; m_ram = orm;
                        e = q.pop_front();
                        m_load(e);
                    end
                end else if (mhr_enable_req) begin
                    if (q.size() != 0) begin m_rav = 1; m_ram = orm; end
                end else begin
                    q.delete();
                end
            end else if (req_valid) begin
                e.st = req_status; e.h = req_hdr; e.p = req_pfx;
                e.hv = req_hdr_vld; e.pp = req_pfx_pres;
                if (mhr_enable_req && stat_cur[m_fep]) begin
                    if (q.size() < DEPTH) q.push_back(e);
                    else m_ovf = 1;
                end else begin
                    m_load(e);
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1 fep", 160'(fep), 160'(m_fep));
            chk("R2 hdr_log", 160'(hdr_log), 160'(m_hdr));
            chk("R3 pfx_log", {31'b0, pfx_log_present, pfx_log}, {31'b0, m_pflag, m_pfx});
            chk("R4 ovf_pulse", 160'(ovf_pulse), 160'(m_ovf));
            chk("R6 R7 reassert", {127'b0, reassert_valid, reassert_mask},
                {127'b0, m_rav, m_ram});
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input bit rq, input int b, input bit hv, input bit pp,
                        input bit wr, input logic [31:0] clr);
        req_valid    = rq;
        req_status   = rq ? (32'h1 << b) : '0;
        req_hdr      = hdr_pat;
        req_pfx      = pfx_pat;
        req_hdr_vld  = hv;
        req_pfx_pres = pp;
        stat_cur     = stat_reg;
        stat_wr      = wr;
        stat_new     = stat_reg & ~clr;
        @(negedge clk);
        if (wr) stat_reg = stat_new;
        else if (rq) stat_reg |= req_status;
        if (reassert_valid) stat_reg |= reassert_mask;
        req_valid = 1'b0; stat_wr = 1'b0;
        stat_cur  = stat_reg;
    endtask

    localparam logic [127:0] H  = 128'h0D0E0F10_090A0B0C_05060708_01020304;
    localparam logic [127:0] HS = 128'h100F0E0D_0C0B0A09_08070605_04030201;
    localparam logic [127:0] P  = 128'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D4;
    localparam logic [127:0] PS = 128'hA4A3A2A1_B4B3B2B1_C4C3C2C1_D4D3D2D1;
    localparam logic [31:0]  QM = (32'h1 << 7) | (32'h1 << 9) | (32'h1 << 12) | (32'h1 << 14);

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        // R10 reset state, R9 capability
        chk("R10 fep", 160'(fep), 160'd0);
        chk("R10 logs", {hdr_log, 32'b0}, 160'd0);
        chk("R10 flags", 160'({pfx_log_present, ovf_pulse, reassert_valid}), 160'd0);
        chk("R9 capable", 160'(mhr_capable), 160'd1);

        // R1 R2 R3 direct logging with recording off
        hdr_pat = H; pfx_pat = P; pfx_support_en = 1'b1;
        step(1, 5, 1, 1, 0, '0);
        chk("R1 fep=5", 160'(fep), 160'd5);
        chk("R2 swapped hdr", 160'(hdr_log), 160'(HS));
        chk("R3 prefix kept", 160'({pfx_log_present, pfx_log}), 160'({1'b1, PS}));
        pfx_support_en = 1'b0;
        step(1, 3, 0, 1, 0, '0);
        chk("R1 fep=3", 160'(fep), 160'd3);
        chk("R2 hdr zero", 160'(hdr_log), 160'd0);
        chk("R3 prefix dropped", 160'({pfx_log_present, pfx_log}), 160'd0);

        // R4 queueing and overflow
        mhr_enable_req = 1'b1; pfx_support_en = 1'b1;
        #1 chk("R9 enabled", 160'(mhr_enabled), 160'd1);
        step(1, 7, 1, 0, 0, '0);
        step(1, 9, 1, 1, 0, '0);
        step(1, 12, 0, 0, 0, '0);
        step(1, 14, 1, 0, 0, '0);
        chk("R4 log kept", 160'(fep), 160'd3);
        step(1, 20, 1, 0, 0, '0);
        chk("R4 overflow", 160'(ovf_pulse), 160'd1);
        @(negedge clk);
        chk("R4 single pulse", 160'(ovf_pulse), 160'd0);

        // R7 write that keeps the first-error bit
        step(0, 0, 0, 0, 1, 32'h1 << 5);
        chk("R7 reassert", 160'({reassert_valid, reassert_mask}), 160'({1'b1, QM}));
        chk("R7 fep held", 160'(fep), 160'd3);

        // R6 clear first error (and try to clear queued ones)
        step(0, 0, 0, 0, 1, (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 9));
        chk("R6 pop fep", 160'(fep), 160'd7);
        chk("R6 reassert", 160'({reassert_valid, reassert_mask}), 160'({1'b1, QM}));
        chk("R6 status back", 160'(stat_reg & QM), 160'(QM));
        step(0, 0, 0, 0, 1, 32'h1 << 7);
        chk("R6 next fep", 160'(fep), 160'd9);
        step(0, 0, 0, 0, 1, 32'h1 << 9);
        step(0, 0, 0, 0, 1, 32'h1 << 12);
        chk("R6 fep=14", 160'(fep), 160'd14);
        // R5 clear with empty queue
        step(0, 0, 0, 0, 1, 32'h1 << 14);
        chk("R5 fep cleared", 160'(fep), 160'd0);
        chk("R5 logs cleared", 160'({pfx_log_present, hdr_log}), 160'd0);

        // R8 flush when recording turned off
        step(1, 4, 1, 0, 0, '0);
        step(1, 6, 1, 0, 0, '0);
        step(1, 8, 1, 0, 0, '0);
        mhr_enable_req = 1'b0;
        step(0, 0, 0, 0, 1, '0);
        mhr_enable_req = 1'b1;
        step(0, 0, 0, 0, 1, 32'h1 << 4);
        chk("R8 flushed", 160'(fep), 160'd0);
        chk("R8 no reassert", 160'(reassert_valid), 160'd0);

        // R11 write and request in the same cycle
        stat_reg = '0;
        step(1, 10, 1, 0, 0, '0);
        chk("R11 setup", 160'(fep), 160'd10);
        step(1, 11, 1, 0, 1, 32'h1 << 10);
        chk("R11 request ignored", 160'(fep), 160'd0);
        step(1, 13, 0, 0, 0, '0);
        chk("R11 later request", 160'(fep), 160'd13);

        mhr_enable_req = 1'b0;
        #1 chk("R9 disabled", 160'(mhr_enabled), 160'd0);

        // mixed traffic against the reference
        for (int n = 0; n < 2000; n++) begin
            int r;
            r = int'($urandom % 100);
            hdr_pat = {$urandom, $urandom, $urandom, $urandom};
            pfx_pat = {$urandom, $urandom, $urandom, $urandom};
            if (r < 3) mhr_enable_req = ~mhr_enable_req;
            if (r >= 3 && r < 8) pfx_support_en = ~pfx_support_en;
            if (r < 45)
                step(1, 1 + int'($urandom % 31), 1'($urandom), 1'($urandom), 0, '0);
            else if (r < 50)
                step(1, 1 + int'($urandom % 31), 1'($urandom), 1'($urandom), 1,
                     32'h1 << fep);
            else if (r < 70)
                step(0, 0, 0, 0, 1, 32'h1 << fep);
            else if (r < 78)
                step(0, 0, 0, 0, 1, 32'h1 << ($urandom % 32));
            else
                step(0, 0, 0, 0, 0, '0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule